// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus target that owns a small bank of configuration bytes for a clock-control block. A system clock oversamples the bus lines through a synchroniser. Start and stop conditions and clock edges are recovered from the synchronised samples. SDA is pulled low through an open-drain enable when the slave acknowledges or sends a zero bit.

Transfers are always sequential block transfers from byte 0. A write carries the address, then a command byte and a count byte, which are acknowledged and discarded, then data bytes. A read returns a fixed count byte first, then the register bytes in order. The bank is presented as one flat parallel bus.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 with the direction bit in bit 0. Any other address gets no acknowledge, and SDA stays released until the next start.
- R2: In a write, the two bytes after the address are each acknowledged and leave every register unchanged.
- R3: Write data bytes after those two go into registers 0, 1, 2 and onward, in that order. Each byte is taken MSB first, and each is acknowledged.
- R4: A stop after any complete data byte keeps the bytes already written and leaves the rest unchanged. A byte cut short by a stop is discarded.
- R5: Write data bytes beyond the last register are acknowledged and change nothing.
- R6: A read sends the count value 6, then registers 0 to 5, each MSB first. Every later byte reads 0xFF for as long as the master acknowledges.
- R7: After the master answers a read byte with NACK, the slave drives SDA no more until the next start.
- R8: At reset, register 0 is 0x00, registers 1 to 5 are 0xFF, and SDA is released.
- R9: The SDA drive enable changes only while SCL is low. It is released after the ninth clock of each byte.
- R10: Register k appears on cfg_bytes[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_bytes | output | 48 | Register bank, register k on bits 8k+7:8k |

## Verification
A wrong byte position shows on cfg_bytes right after the ninth clock of the data byte that was misplaced. It also shows in the read-back stream one byte time later than expected. A wrong bit count or phase shows in the next acknowledge slot: the ACK is missing, or SDA is held low while SCL is high, and this is seen within one byte. A slave stuck in the drive state after NACK or stop shows as SDA held low on the idle bus within a few system clocks.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  // Power-on value of register idx: register 0 is cleared, the enable bytes are all ones
  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [8*NUM_REGS-1:0] regs_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [7:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val <= reg_default(k);
      else if (wr_en && (wr_idx == IDX_W'(k)))
        val <= wr_data;
    end
    assign regs_flat[8*k +: 8] = val;
  end
endmodule

// File: rtl/cfg_i2c_proto.sv
module cfg_i2c_proto
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] COUNT_VALUE = 8'd6,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(NUM_REGS + 3)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_lvl,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_evt,
  input  logic                  stop_evt,
  input  logic [8*NUM_REGS-1:0] regs_flat,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [7:0]            wr_data,
  output logic                  sda_oe
);
  localparam logic [CNT_W-1:0] W_FIRST = CNT_W'(2);
  localparam logic [CNT_W-1:0] W_END   = CNT_W'(NUM_REGS + 2);
  localparam logic [CNT_W-1:0] R_END   = CNT_W'(NUM_REGS + 1);

  phase_t           phase;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, tx_sh;
  logic             is_addr, is_read, nack;
  logic [CNT_W-1:0] wcnt, rcnt;
  logic [CNT_W-1:0] data_pos;
  logic             byte_done;

  // Byte sent in read slot pos: count byte, then registers, then filler
  function automatic logic [7:0] pick(input logic [CNT_W-1:0] pos,
                                      input logic [8*NUM_REGS-1:0] flat);
    logic [7:0] v;
    v = (pos == '0) ? COUNT_VALUE : 8'hFF;
    for (int k = 0; k < NUM_REGS; k++)
      if (pos == CNT_W'(k + 1)) v = flat[8*k +: 8];
    return v;
  endfunction

  assign byte_done = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8) && !start_evt && !stop_evt;
  assign data_pos  = wcnt - W_FIRST;
  assign wr_en     = byte_done && !is_addr && (wcnt >= W_FIRST) && (wcnt < W_END);
  assign wr_idx    = data_pos[IDX_W-1:0];
  assign wr_data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      tx_sh   <= '0;
      is_addr <= 1'b0;
      is_read <= 1'b0;
      nack    <= 1'b0;
      wcnt    <= '0;
      rcnt    <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_RX;
      bitcnt  <= '0;
      is_addr <= 1'b1;
      wcnt    <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (is_addr) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                phase   <= PH_RX_ACK;
                is_read <= shreg[0];
                rcnt    <= '0;
              end else begin
                phase <= PH_IDLE;
              end
              is_addr <= 1'b0;
            end else begin
              sda_oe <= 1'b1;
              phase  <= PH_RX_ACK;
              if (wcnt != W_END) wcnt <= wcnt + CNT_W'(1);
            end
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (is_read) begin
              tx_sh  <= pick(rcnt, regs_flat);
              sda_oe <= ~pick(rcnt, regs_flat)[7];
              if (rcnt != R_END) rcnt <= rcnt + CNT_W'(1);
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              phase  <= PH_TX_ACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            nack <= sda_lvl;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (nack) begin
              phase <= PH_IDLE;
            end else begin
              tx_sh  <= pick(rcnt, regs_flat);
              sda_oe <= ~pick(rcnt, regs_flat)[7];
              if (rcnt != R_END) rcnt <= rcnt + CNT_W'(1);
              phase  <= PH_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] COUNT_VALUE = 8'd6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] cfg_bytes
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic             start_evt, stop_evt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfg_i2c_proto #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .COUNT_VALUE(COUNT_VALUE)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .regs_flat(cfg_bytes),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_flat(cfg_bytes)
  );
endmodule

// File: rtl/cfg_i2c_chk.sv
module cfg_i2c_chk #(
  parameter int NUM_REGS = 6,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_lvl,
  input logic                  sda_oe,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [8*NUM_REGS-1:0] cfg_bytes
);
  // R9
  oe_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R5
  wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  // R2
  cfg_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bytes) |-> $past(wr_en));
endmodule

bind cfg_i2c_slave cfg_i2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .wr_en(wr_en), .wr_idx(wr_idx),
  .cfg_bytes(cfg_bytes)
);

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [47:0] cfg_bytes;
  logic sda_line;
  logic [7:0] exp_reg [6];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_bytes(cfg_bytes)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: drive enable may change only while SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl) begin
      failures++;
      $display("FAIL R9 actual=oe changed with SCL high expected=SCL low");
    end
    oe_prev <= sda_oe;
  end

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    m_sda = v; waitq(1);
    scl = 1'b1; waitq(1);
    s = sda_line; waitq(1);
    scl = 1'b0; waitq(1);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; waitq(1);
    scl = 1'b1; waitq(1);
    m_sda = 1'b0; waitq(1);
    scl = 1'b0; waitq(1);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; waitq(1);
    scl = 1'b1; waitq(1);
    m_sda = 1'b1; waitq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = (s == 1'b0);
    m_sda = 1'b1;
  endtask

  task automatic recv_byte(input logic give_nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(give_nack, s);
    m_sda = 1'b1;
  endtask

  function automatic logic [47:0] exp_flat();
    logic [47:0] f;
    for (int k = 0; k < 6; k++) f[8*k +: 8] = exp_reg[k];
    return f;
  endfunction

  task automatic write_header(input string req);
    logic a;
    i2c_start();
    send_byte(8'hD2, a); chk({req, " R1 addr ack"}, a, 1);
    send_byte(8'h5A, a); chk("R2 cmd ack", a, 1);
    send_byte(8'hC3, a); chk("R2 count ack", a, 1);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 6; k++) exp_reg[k] = (k == 0) ? 8'h00 : 8'hFF;
    chk("R8 reset regs", cfg_bytes, exp_flat());
    chk("R8 reset sda_oe", sda_oe, 0);
    chk("R10 byte1 position", cfg_bytes[15:8], 8'hFF);
  endtask

  task automatic t_header_only();
    write_header("R2");
    i2c_stop();
    chk("R2 regs unchanged", cfg_bytes, exp_flat());
  endtask

  task automatic t_full_write();
    logic a;
    logic [7:0] d [6] = '{8'h11, 8'h82, 8'h3C, 8'hA4, 8'h05, 8'h96};
    write_header("R3");
    for (int k = 0; k < 6; k++) begin
      send_byte(d[k], a); chk("R3 data ack", a, 1);
      exp_reg[k] = d[k];
    end
    i2c_stop();
    chk("R3 all regs", cfg_bytes, exp_flat());
    chk("R10 byte0 position", cfg_bytes[7:0], 8'h11);
    chk("R10 byte5 position", cfg_bytes[47:40], 8'h96);
  endtask

  task automatic t_partial();
    logic a, s;
    write_header("R4");
    send_byte(8'hE1, a); exp_reg[0] = 8'hE1;
    send_byte(8'h7E, a); exp_reg[1] = 8'h7E;
    i2c_stop();
    chk("R4 two bytes then stop", cfg_bytes, exp_flat());
    write_header("R4");
    send_byte(8'h40, a); exp_reg[0] = 8'h40;
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
    i2c_stop();
    chk("R4 cut byte discarded", cfg_bytes, exp_flat());
  endtask

  task automatic t_extra();
    logic a;
    write_header("R5");
    for (int k = 0; k < 6; k++) begin
      send_byte(8'h20 + 8'(k), a);
      exp_reg[k] = 8'h20 + 8'(k);
    end
    send_byte(8'hEE, a); chk("R5 extra byte ack", a, 1);
    send_byte(8'hDD, a); chk("R5 second extra ack", a, 1);
    i2c_stop();
    chk("R5 extras ignored", cfg_bytes, exp_flat());
  endtask

  task automatic t_wrong_addr();
    logic a;
    i2c_start();
    send_byte(8'hA0, a); chk("R1 foreign addr no ack", a, 0);
    send_byte(8'h00, a); chk("R1 no ack after foreign addr", a, 0);
    send_byte(8'h00, a);
    i2c_stop();
    chk("R1 regs unchanged", cfg_bytes, exp_flat());
    i2c_start();
    send_byte(8'hD0, a); chk("R1 neighbour addr no ack", a, 0);
    i2c_stop();
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hD3, a); chk("R1 read addr ack", a, 1);
    recv_byte(1'b0, b); chk("R6 count byte", b, 8'd6);
    for (int k = 0; k < 6; k++) begin
      recv_byte(1'b0, b); chk("R6 reg byte", b, exp_reg[k]);
    end
    recv_byte(1'b0, b); chk("R6 filler", b, 8'hFF);
    recv_byte(1'b1, b); chk("R6 filler last", b, 8'hFF);
    waitq(1);
    chk("R7 released after nack", sda_oe, 0);
    chk("R7 line high after nack", sda_line, 1);
    i2c_stop();
    i2c_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b); chk("R7 count then nack", b, 8'd6);
    scl = 1'b1; waitq(3);
    chk("R7 no drive after early nack", sda_oe, 0);
    scl = 1'b0; waitq(1);
    i2c_stop();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_header_only();
    t_full_write();
    t_read();
    t_partial();
    t_extra();
    t_wrong_addr();
    t_read();
    done = 1'b1;
    finish_run();
  end
endmodule